// File: doc/BRIEF.md
# NAND Page ECC Parity Accumulator

This block sits in the write and read paths of a NAND flash controller. It computes, over a stream of bytes, the Hamming-style parity that detects and locates single-bit errors in a page. Each accepted byte adds two things. It XORs a set of column parities into a small register; each column parity covers the byte bits whose index has a given address bit clear or set. If the byte has odd parity, it also folds the running byte index and its complement into two line parity words. A byte counter advances with every accepted byte.

The byte stream passes through the block with one register stage, so the block can sit inline on a data path. A synchronous clear starts a new page. Packing the parity into stored ECC bytes, comparing syndromes and correcting errors are left to logic further down the path.

Top module: `nand_ecc_accum`

## Requirements
- R1: After the asynchronous active-low reset, the column parity, both line parity words, the byte count, validOut and dataOut are all zero.
- R2: For each accepted byte (validIn high, clearIn low), the column parity register XORs in a 6-bit contribution. For address bit j (0..2), contribution bit 2j is the parity of the data bits whose index has bit j equal to 0, and bit 2j+1 is the parity of those whose index has bit j equal to 1. For example, bit 3 covers data bits {2,3,6,7} and bit 4 covers {0,1,2,3}.
- R3: When an accepted byte has odd parity (XOR of all eight bits is 1), line parity word 0 XORs in the bitwise complement of the byte count as it stood before that byte, and line parity word 1 XORs in that count itself.
- R4: When an accepted byte has even parity, both line parity words keep their values.
- R5: The byte count rises by one for each accepted byte and wraps from 65535 to 0.
- R6: clearIn high sets the column parity, both line parity words and the byte count to zero at the next edge, and a byte presented with validIn in the same cycle is not accumulated.
- R7: With validIn low and clearIn low, none of the parity registers or the byte count changes, whatever dataIn holds.
- R8: dataOut equals dataIn and validOut equals validIn from the previous clock cycle, whether or not clearIn is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Synchronous clear of the parity state and the count |
| validIn | input | 1 | Qualifies dataIn |
| dataIn | input | 8 | Input byte |
| validOut | output | 1 | validIn delayed by one cycle |
| dataOut | output | 8 | dataIn delayed by one cycle |
| colParity | output | 6 | Accumulated column parity |
| lineParity0 | output | 16 | Line parity fed with the complemented count |
| lineParity1 | output | 16 | Line parity fed with the count |
| byteCount | output | 16 | Number of accepted bytes modulo 65536 |

## Verification
Every result, whether parity, count, clear or the passed-through byte, is due at the first rising edge after the input is presented. No path is longer than one register. The bench changes inputs on the falling edge and compares against its arithmetic model on the following falling edge, so it reads each output exactly one register stage after the stimulus. It sweeps all 256 byte values, runs idle cycles with changing data, and issues a clear together with a valid odd byte. A full run of 65536 bytes checks the count wrap, and the line parity fold is checked with counts up to 0xFFFF.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearState;
    logic accept;
  } eccStrobes_t;
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DATA_W),
  localparam int COL_W = 2 * ADDR_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [COL_W-1:0]  colBits,
  output logic              oddByte
);
  function automatic logic [DATA_W-1:0] hiMask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> j) & 1) == 1;
    return m;
  endfunction

  for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
    localparam logic [DATA_W-1:0] MASK_HI = hiMask(j);
    assign colBits[2*j]   = ^(data & ~MASK_HI);
    assign colBits[2*j+1] = ^(data & MASK_HI);
  end

  assign oddByte = ^data;
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
(
  input  logic        clearIn,
  input  logic        validIn,
  output eccStrobes_t strobes
);
  always_comb begin
    strobes.clearState = clearIn;
    strobes.accept     = validIn & ~clearIn; // clear wins
  end
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 16,
  localparam int COL_W = 2 * $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobes_t       strobes,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [COL_W-1:0]  colParity,
  output logic [CNT_W-1:0]  lineParity0,
  output logic [CNT_W-1:0]  lineParity1,
  output logic [CNT_W-1:0]  byteCount
);
  logic [COL_W-1:0] colBits;
  logic             oddByte;

  ecc_byte_parity #(.DATA_W(DATA_W)) i_parity (
    .data    (dataIn),
    .colBits (colBits),
    .oddByte (oddByte)
  );

  // pass-through stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      dataOut  <= '0;
    end else begin
      validOut <= validIn;
      dataOut  <= dataIn;
    end
  end

  // accumulators
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colParity   <= '0;
      lineParity0 <= '0;
      lineParity1 <= '0;
      byteCount   <= '0;
    end else if (strobes.clearState) begin
      colParity   <= '0;
      lineParity0 <= '0;
      lineParity1 <= '0;
      byteCount   <= '0;
    end else if (strobes.accept) begin
      colParity <= colParity ^ colBits;
      if (oddByte) begin
        lineParity0 <= lineParity0 ^ ~byteCount;
        lineParity1 <= lineParity1 ^ byteCount;
      end
      byteCount <= byteCount + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 16,
  localparam int COL_W = 2 * $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearIn,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [COL_W-1:0]  colParity,
  output logic [CNT_W-1:0]  lineParity0,
  output logic [CNT_W-1:0]  lineParity1,
  output logic [CNT_W-1:0]  byteCount
);
  eccStrobes_t strobes;

  ecc_ctrl i_ctrl (
    .clearIn (clearIn),
    .validIn (validIn),
    .strobes (strobes)
  );

  ecc_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .validIn     (validIn),
    .dataIn      (dataIn),
    .validOut    (validOut),
    .dataOut     (dataOut),
    .colParity   (colParity),
    .lineParity0 (lineParity0),
    .lineParity1 (lineParity1),
    .byteCount   (byteCount)
  );
endmodule

// File: rtl/nand_ecc_accum_checker.sv
module nand_ecc_accum_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 16,
  parameter int COL_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearIn,
  input logic              validIn,
  input logic [DATA_W-1:0] dataIn,
  input logic              validOut,
  input logic [DATA_W-1:0] dataOut,
  input logic [COL_W-1:0]  colParity,
  input logic [CNT_W-1:0]  lineParity0,
  input logic [CNT_W-1:0]  lineParity1,
  input logic [CNT_W-1:0]  byteCount
);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !clearIn) |=> byteCount == $past(byteCount) + 1'b1);

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (colParity == '0 && lineParity0 == '0 &&
                 lineParity1 == '0 && byteCount == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!validIn && !clearIn) |=> ($stable(colParity) && $stable(lineParity0) &&
                                $stable(lineParity1) && $stable(byteCount)));

  a_r4_even_hold: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !clearIn && !(^dataIn)) |=>
      ($stable(lineParity0) && $stable(lineParity1)));

  a_r3_odd_fold: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !clearIn && (^dataIn)) |=>
      (lineParity1 == ($past(lineParity1) ^ $past(byteCount)) &&
       lineParity0 == ($past(lineParity0) ^ ~$past(byteCount))));

  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dataOut == $past(dataIn) && validOut == $past(validIn)));
endmodule

bind nand_ecc_accum nand_ecc_accum_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .COL_W(COL_W)
) i_checker (
  .clk(clk), .rstN(rstN), .clearIn(clearIn), .validIn(validIn),
  .dataIn(dataIn), .validOut(validOut), .dataOut(dataOut),
  .colParity(colParity), .lineParity0(lineParity0),
  .lineParity1(lineParity1), .byteCount(byteCount)
);

// File: tb/test_nand_ecc_accum.sv
`timescale 1ns/1ps
module test_nand_ecc_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearIn = 1'b0;
  logic        validIn = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        validOut;
  logic [7:0]  dataOut;
  logic [5:0]  colParity;
  logic [15:0] lineParity0, lineParity1, byteCount;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [5:0]  mCol = '0;
  logic [15:0] mLp0 = '0, mLp1 = '0, mCnt = '0;

  always #2 clk = ~clk;

  nand_ecc_accum i_nand_ecc_accum (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .validIn(validIn),
    .dataIn(dataIn), .validOut(validOut), .dataOut(dataOut),
    .colParity(colParity), .lineParity0(lineParity0),
    .lineParity1(lineParity1), .byteCount(byteCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] colOf(input logic [7:0] b);
    logic [5:0] c = '0;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if (((i / (1 << j)) % 2) == 1) c[2*j+1] ^= b[i];
        else c[2*j] ^= b[i];
    return c;
  endfunction

  task automatic checkState(input string tag);
    check({tag, " colParity"}, int'(colParity), int'(mCol));
    check({tag, " lineParity0"}, int'(lineParity0), int'(mLp0));
    check({tag, " lineParity1"}, int'(lineParity1), int'(mLp1));
    check({tag, " byteCount"}, int'(byteCount), int'(mCnt));
  endtask

  // drive on falling edge, compare at next falling edge
  task automatic step(input logic v, input logic clr, input logic [7:0] d,
                      input string tag, input bit full);
    clearIn = clr; validIn = v; dataIn = d;
    @(posedge clk);
    @(negedge clk);
    if (clr) begin
      mCol = '0; mLp0 = '0; mLp1 = '0; mCnt = '0;
    end else if (v) begin
      mCol ^= colOf(d);
      if ((^d) == 1'b1) begin
        mLp0 ^= ~mCnt;
        mLp1 ^= mCnt;
      end
      mCnt = mCnt + 16'd1;
    end
    if (full) begin
      checkState(tag);
      check("R8 dataOut", int'(dataOut), int'(d));
      check("R8 validOut", int'(validOut), int'(v));
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkState("R1 reset");
    check("R1 validOut", int'(validOut), 0);
    check("R1 dataOut", int'(dataOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: exhaustive sweep of byte values
    for (int b = 0; b < 256; b++) step(1'b1, 1'b0, 8'(b), "R2/R3/R4/R5 sweep", 1'b1);

    // R7 idle with changing data
    for (int b = 0; b < 16; b++) step(1'b0, 1'b0, 8'(b * 37 + 5), "R7 idle", 1'b1);

    // R6 clear together with an odd valid byte
    step(1'b1, 1'b1, 8'h01, "R6 clear", 1'b1);
    step(1'b1, 1'b0, 8'h80, "R2 after clear", 1'b1);

    // R5 wrap: 65536 bytes, odd ones fold large counts (R3)
    step(1'b0, 1'b1, 8'h00, "R6 clear", 1'b1);
    for (int i = 0; i < 65536; i++)
      step(1'b1, 1'b0, 8'(i ^ (i >> 8)), "R5 long run", 1'b0);
    checkState("R5 wrapped");
    check("R5 count wrapped to zero", int'(byteCount), 0);
    step(1'b1, 1'b0, 8'h07, "R5 after wrap", 1'b1);
    check("R5 count one after wrap", int'(byteCount), 1);
    step(1'b0, 1'b0, 8'hFF, "R7 idle after wrap", 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule